// File: doc/BRIEF.md
# Dual-Rate SPI Write Master

This block is an SPI master (clock idle low, data launched while the clock is low, sampled on the rising edge) that serialises a stream of bytes towards one of several devices sharing the bus. Each byte can go out in one of two ways. Normal rate puts one bit per clock pulse on the data-out line. Fast-write rate puts two bits per pulse: the upper bit of each pair goes on the data-out line and the lower bit goes on an auxiliary select line that doubles as a second data wire.

The host pushes bytes through a valid/ready port. Each byte carries a device index, a fast-write request, a flag that says whether transmit data is present, and an end-of-command marker. Every byte produces one result on a valid/ready output holding the bits sampled from the data-in line. Back-pressure works in both directions. The input is refused while a byte is shifting, and it is also refused while an earlier result is still waiting to be taken. A result can be taken in the same cycle that the next byte is accepted. A parameter sets the number of system clocks in each half of an SCLK period.

Top module: `dualrate_spi_wr`

## Requirements
- R1: In normal rate a byte produces exactly 8 SCLK pulses, with the bit on spi_do at the n-th rising edge equal to byte bit 7-n (MSB first). spi_cs2 stays low for the whole byte.
- R2: In fast rate a byte produces exactly 4 SCLK pulses. At the n-th rising edge, spi_do carries byte bit 7-2n and spi_cs2 carries byte bit 6-2n, so the pairs go out as [7:6], [5:4], [3:2], [1:0].
- R3: Fast rate is used only when in_dev equals 1 and in_fast is 1. Any other device index with in_fast set is sent at normal rate.
- R4: SCLK low and high phases each last CLK_DIV system clocks. spi_do, spi_cs2, spi_cs0_n and spi_cs1_n do not change while SCLK is high. From the accepting clock edge to the edge that raises rd_valid takes 2*pulses*CLK_DIV clocks.
- R5: A byte offered with in_tx_en low is sent as 0x00, whatever in_data holds.
- R6: While a byte shifts, device index 2 drives spi_cs0_n high and spi_cs1_n low, and every other index drives spi_cs0_n low and spi_cs1_n high. Both lines are never low together.
- R7: After a byte marked in_last, spi_cs0_n and spi_cs1_n are both high in the cycle its result appears. After an unmarked byte the select pattern of that byte is kept.
- R8: spi_di is sampled at every SCLK rising edge and shifted in MSB first. At normal rate rd_data is the 8 samples. At fast rate rd_data[3:0] holds the 4 samples and rd_data[7:4] is zero.
- R9: in_ready is low from the accepting edge until the last pulse ends. It is also low while rd_valid is high and rd_ready is low, and during that wait rd_data holds steady. With rd_valid and rd_ready both high, in_ready rises in the same cycle, so a result pop and a byte accept can share one edge.
- R10: During and after reset, before any byte: spi_cs0_n and spi_cs1_n high, spi_sclk, spi_do and spi_cs2 low, rd_valid low, in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_data | input | 8 | Transmit byte |
| in_tx_en | input | 1 | 1: send in_data, 0: send zeros |
| in_dev | input | 2 | Target device index |
| in_fast | input | 1 | Fast-write request (honoured for device 1 only) |
| in_last | input | 1 | Byte ends the command; selects released afterwards |
| rd_valid | output | 1 | Readback byte available |
| rd_ready | input | 1 | Consumer takes the readback byte |
| rd_data | output | 8 | Bits sampled from spi_di during the byte |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_do | output | 1 | Serial data out (upper bit of a pair in fast rate) |
| spi_di | input | 1 | Serial data in |
| spi_cs0_n | output | 1 | Active-low select line 0 |
| spi_cs1_n | output | 1 | Active-low select line 1 |
| spi_cs2 | output | 1 | Auxiliary line, lower bit of a pair in fast rate, idle low |

## Verification
Two events can land on the same clock edge: the consumer draining a finished result, and the host's next byte being accepted. The bench keeps in_valid high with a second byte queued while rd_ready is held low. It checks that in_ready stays low and the result stays steady. It then raises rd_ready and expects in_ready high in that same cycle. After the shared edge, rd_valid must be low and the block busy, and the second byte's readback must match what the bench's device model returned. That shows no result was lost or repeated.

// File: rtl/drspi_pkg.sv
package drspi_pkg;
  localparam int BYTE_W = 8;
  localparam int SYM_W  = $clog2(BYTE_W);
  localparam int FAST_SYMS = BYTE_W / 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam logic [1:0] DEV_FAST_CAPABLE = 2'd1;
  localparam logic [1:0] DEV_ALT_SELECT   = 2'd2;
endpackage

// File: rtl/drspi_tick.sv
module drspi_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  generate
    if (CLK_DIV <= 1) begin : g_direct
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = run;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign tick = run && (cnt_q == CW'(CLK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
      end

      assert_phase_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/drspi_shifter.sv
module drspi_shifter
  import drspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              load_fast,
  input  logic              sample,
  input  logic              step,
  input  logic              done,
  input  logic              di,
  output logic              do_bit,
  output logic              cs2_bit,
  output logic              sym_last,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic [SYM_W-1:0]  sym_q;
  logic              fast_q;

  assign sym_last = fast_q ? (sym_q == SYM_W'(FAST_SYMS - 1))
                           : (sym_q == SYM_W'(BYTE_W - 1));
  assign do_bit  = tx_q[BYTE_W-1];
  assign cs2_bit = fast_q & tx_q[BYTE_W-2];
  assign rx_byte = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      sym_q  <= '0;
      fast_q <= 1'b0;
    end else if (load) begin
      tx_q   <= load_data;
      sym_q  <= '0;
      fast_q <= load_fast;
    end else if (done) begin
      tx_q   <= '0;
      sym_q  <= '0;
      fast_q <= 1'b0;
    end else if (step) begin
      tx_q   <= fast_q ? {tx_q[BYTE_W-3:0], 2'b00} : {tx_q[BYTE_W-2:0], 1'b0};
      sym_q  <= sym_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_q <= '0;
    else if (load)   rx_q <= '0;
    else if (sample) rx_q <= {rx_q[BYTE_W-2:0], di};
  end

  assert_fast_sym_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fast_q |-> (sym_q < SYM_W'(FAST_SYMS)));
  assert_idle_data_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!do_bit && !cs2_bit));
endmodule

// File: rtl/drspi_select.sv
module drspi_select
  import drspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] dev,
  input  logic       last,
  input  logic       done,
  output logic       cs0_n,
  output logic       cs1_n
);
  logic cs0_q, cs1_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs0_q  <= 1'b1;
      cs1_q  <= 1'b1;
      last_q <= 1'b0;
    end else if (load) begin
      cs0_q  <= (dev == DEV_ALT_SELECT);
      cs1_q  <= (dev != DEV_ALT_SELECT);
      last_q <= last;
    end else if (done && last_q) begin
      cs0_q  <= 1'b1;
      cs1_q  <= 1'b1;
      last_q <= 1'b0;
    end
  end

  assign cs0_n = cs0_q;
  assign cs1_n = cs1_q;

  assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs0_q && !cs1_q));
endmodule

// File: rtl/dualrate_spi_wr.sv
module dualrate_spi_wr
  import drspi_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_tx_en,
  input  logic [1:0] in_dev,
  input  logic       in_fast,
  input  logic       in_last,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       spi_sclk,
  output logic       spi_do,
  input  logic       spi_di,
  output logic       spi_cs0_n,
  output logic       spi_cs1_n,
  output logic       spi_cs2
);
  phase_e      state_q;
  logic        tick, accept, to_high, to_low, sym_last, byte_done, sym_step;
  logic        sclk_q, rd_valid_q;
  logic [7:0]  rd_data_q, rx_byte;
  logic [7:0]  tx_word;
  logic        use_fast;

  assign in_ready  = (state_q == PH_IDLE) && (!rd_valid_q || rd_ready);
  assign accept    = in_valid && in_ready;
  assign to_high   = (state_q == PH_LOW)  && tick;
  assign to_low    = (state_q == PH_HIGH) && tick;
  assign byte_done = to_low && sym_last;
  assign sym_step  = to_low && !sym_last;
  assign tx_word   = in_tx_en ? in_data : 8'h00;
  assign use_fast  = in_fast && (in_dev == DEV_FAST_CAPABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else begin
      case (state_q)
        PH_IDLE: if (accept)  state_q <= PH_LOW;
        PH_LOW:  if (to_high) state_q <= PH_HIGH;
        PH_HIGH: if (to_low)  state_q <= sym_last ? PH_IDLE : PH_LOW;
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sclk_q <= 1'b0;
    else if (to_high) sclk_q <= 1'b1;
    else if (to_low)  sclk_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else if (byte_done) begin
      rd_valid_q <= 1'b1;
      rd_data_q  <= rx_byte;
    end else if (rd_ready) begin
      rd_valid_q <= 1'b0;
    end
  end

  drspi_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q != PH_IDLE),
    .tick (tick)
  );

  drspi_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_data(tx_word),
    .load_fast(use_fast),
    .sample   (to_high),
    .step     (sym_step),
    .done     (byte_done),
    .di       (spi_di),
    .do_bit   (spi_do),
    .cs2_bit  (spi_cs2),
    .sym_last (sym_last),
    .rx_byte  (rx_byte)
  );

  drspi_select u_sel (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .dev  (in_dev),
    .last (in_last),
    .done (byte_done),
    .cs0_n(spi_cs0_n),
    .cs1_n(spi_cs1_n)
  );

  assign spi_sclk = sclk_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  assert_hold_while_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HIGH) |-> ($stable(spi_do) && $stable(spi_cs2) &&
                              $stable(spi_cs0_n) && $stable(spi_cs1_n)));
  assert_idle_sclk_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE) |-> !spi_sclk);
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/dualrate_spi_wr_test.sv
module dualrate_spi_wr_test;
  localparam int TB_DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_tx_en = 1'b1;
  logic [1:0] in_dev = 2'd0;
  logic       in_fast = 1'b0;
  logic       in_last = 1'b1;
  logic       rd_valid;
  logic       rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic       spi_sclk, spi_do, spi_di, spi_cs0_n, spi_cs1_n, spi_cs2;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int         rise_cnt = 0;
  int         base = 0;
  logic       prev_sclk = 1'b0;
  logic [7:0] miso_q = 8'h00;
  logic       cap_do [64];
  logic       cap_cs2 [64];
  logic       cap_cs0 [64];
  logic       cap_cs1 [64];

  always #2.5 clk = ~clk;

  dualrate_spi_wr #(.CLK_DIV(TB_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tx_en(in_tx_en), .in_dev(in_dev), .in_fast(in_fast),
    .in_last(in_last), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .spi_sclk(spi_sclk), .spi_do(spi_do), .spi_di(spi_di),
    .spi_cs0_n(spi_cs0_n), .spi_cs1_n(spi_cs1_n), .spi_cs2(spi_cs2)
  );

  // Device model: bit k of the reply byte is presented before the k-th rise.
  assign spi_di = ((rise_cnt - base) >= 0 && (rise_cnt - base) < 8)
                  ? miso_q[7 - (rise_cnt - base)] : 1'b0;

  always @(negedge clk) begin
    if (spi_sclk && !prev_sclk) begin
      cap_do[rise_cnt % 64]  <= spi_do;
      cap_cs2[rise_cnt % 64] <= spi_cs2;
      cap_cs0[rise_cnt % 64] <= spi_cs0_n;
      cap_cs1[rise_cnt % 64] <= spi_cs1_n;
      rise_cnt <= rise_cnt + 1;
    end
    prev_sclk <= spi_sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit txen, input logic [1:0] dev,
                      input bit fast, input bit last, input logic [7:0] miso);
    bit         fx;
    int         n, nsym;
    logic [7:0] txv, rebuilt, exp_rd;
    logic       cs2_any;
    bit         cs_ok;
    string      rq;
    fx   = fast && (dev == 2'd1);
    nsym = fx ? 4 : 8;
    txv  = txen ? d : 8'h00;
    @(negedge clk);
    base = rise_cnt;
    miso_q = miso;
    in_data = d; in_tx_en = txen; in_dev = dev; in_fast = fast; in_last = last;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    while (!rd_valid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 2 * nsym * TB_DIV + 1, "R4", "byte duration", n, 2 * nsym * TB_DIV + 1);
    chk(rise_cnt - base == nsym, fx ? "R2" : "R1", "pulse count", rise_cnt - base, nsym);
    rebuilt = 8'h00;
    cs2_any = 1'b0;
    cs_ok = 1'b1;
    for (int i = 0; i < nsym; i++) begin
      int idx;
      idx = (base + i) % 64;
      if (fx) rebuilt = {rebuilt[5:0], cap_do[idx], cap_cs2[idx]};
      else begin
        rebuilt = {rebuilt[6:0], cap_do[idx]};
        cs2_any = cs2_any | cap_cs2[idx];
      end
      if ({cap_cs0[idx], cap_cs1[idx]} != ((dev == 2'd2) ? 2'b10 : 2'b01)) cs_ok = 1'b0;
    end
    rq = !txen ? "R5" : (fx ? "R2" : ((fast && dev != 2'd1) ? "R3" : "R1"));
    chk(rebuilt == txv, rq, "serial byte", rebuilt, txv);
    if (!fx) chk(cs2_any == 1'b0, "R1", "cs2 in normal rate", cs2_any, 0);
    chk(cs_ok, "R6", "select pattern during byte", cs_ok, 1);
    exp_rd = fx ? {4'h0, miso[7:4]} : miso;
    chk(rd_data == exp_rd, "R8", "readback", rd_data, exp_rd);
    if (last) chk({spi_cs0_n, spi_cs1_n} == 2'b11, "R7", "release after last",
                  {spi_cs0_n, spi_cs1_n}, 2'b11);
    else      chk({spi_cs0_n, spi_cs1_n} == ((dev == 2'd2) ? 2'b10 : 2'b01), "R7",
                  "select kept mid command", {spi_cs0_n, spi_cs1_n},
                  (dev == 2'd2) ? 2'b10 : 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({spi_cs0_n, spi_cs1_n, spi_sclk, spi_do, spi_cs2} == 5'b11000, "R10",
        "outputs in reset", {spi_cs0_n, spi_cs1_n, spi_sclk, spi_do, spi_cs2}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({spi_cs0_n, spi_cs1_n, spi_sclk, spi_do, spi_cs2} == 5'b11000, "R10",
        "outputs after reset", {spi_cs0_n, spi_cs1_n, spi_sclk, spi_do, spi_cs2}, 5'b11000);
    chk(in_ready && !rd_valid, "R10", "handshake after reset", {in_ready, rd_valid}, 2'b10);

    // Exhaustive byte sweep: fast on device 1, normal on device 1, fast flag on device 0
    for (int d = 0; d < 256; d++) begin
      send(8'(d), 1'b1, 2'd1, 1'b1, 1'b1, 8'(~d));
      send(8'(d), 1'b1, 2'd1, 1'b0, 1'b1, 8'(d * 7 + 3));
      send(8'(d), 1'b1, 2'd0, 1'b1, 1'b1, 8'(d ^ 8'h5A));
    end

    // Device and rate matrix, including zero fill
    for (int dv = 0; dv < 4; dv++) begin
      for (int f = 0; f < 2; f++) begin
        send(8'hC3, 1'b1, 2'(dv), f[0], 1'b1, 8'h96);
        send(8'hFF, 1'b0, 2'(dv), f[0], 1'b1, 8'h0F);
      end
    end

    // Multi-byte command on device 2, select held until the marked byte
    send(8'h11, 1'b1, 2'd2, 1'b0, 1'b0, 8'h81);
    send(8'h22, 1'b1, 2'd2, 1'b0, 1'b0, 8'h42);
    send(8'h33, 1'b1, 2'd2, 1'b0, 1'b1, 8'h24);
    send(8'hE4, 1'b1, 2'd1, 1'b1, 1'b0, 8'hB0);
    send(8'h1B, 1'b1, 2'd1, 1'b1, 1'b1, 8'h70);

    // R9: result drain and next accept on one edge
    @(negedge clk);
    rd_ready = 1'b0;
    base = rise_cnt; miso_q = 8'h6D;
    in_data = 8'hA5; in_tx_en = 1'b1; in_dev = 2'd0; in_fast = 1'b0; in_last = 1'b1;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_data = 8'h3C;
    while (!rd_valid) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk(!in_ready && rd_valid && rd_data == 8'h6D, "R9", "stall holds result",
          {in_ready, rd_valid, rd_data}, {2'b01, 8'h6D});
      @(negedge clk);
    end
    rd_ready = 1'b1;
    #1;
    chk(in_ready, "R9", "ready with pop", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    base = rise_cnt; miso_q = 8'hC9;
    in_valid = 1'b0;
    chk(!rd_valid && !in_ready, "R9", "pop and accept same edge",
        {rd_valid, in_ready}, 2'b00);
    while (!rd_valid) @(negedge clk);
    chk(rd_data == 8'hC9, "R9", "second byte readback", rd_data, 8'hC9);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule